// File: doc/BRIEF.md
# Speculative Load Disambiguation Unit

This block sits beside the load and store queues of an out-of-order core and decides, cycle by cycle, whether a load that asks to execute may go ahead of the stores that precede it in program order. Stores and loads are allocated into slots with a wrapping age tag. Stores later report their resolved addresses. A load request carries the load's address, and the block answers in the same cycle with a grant and a flag that tells whether the grant was speculative.

A load may pass an older store whose address is known and differs from its own. It never passes an older store whose known address matches. When an older store's address is still unknown, a small table of 2-bit counters, indexed by low bits of the load PC, decides. If the counter allows it, the load issues speculatively. If not, the load waits until every older store address is known. Whenever a store resolves, all younger loads that have already executed are compared against the new address. The oldest one that matches is reported one cycle later on the replay outputs. Its predictor counter is cleared, and it returns to the not-executed state so that it can request again. A load that retires after a speculative issue with no violation raises its counter.

Top module: `spec_ld_order`

## Requirements
- R1: While reset is applied and in the cycles that follow its release, no replay is reported and no grant is raised without a request.
- R2: A load whose older stores all have known addresses that differ from its own is granted with the speculative flag low.
- R3: A load is refused while an older store has a known address equal to the load address. It is granted once that store has been freed.
- R4: With an older store still unresolved and no matching known older store, the load is granted with the speculative flag high if its counter is 2 or 3, and refused if the counter is 0 or 1.
- R5: Age tags are 4 bits and compared modulo 16 (a is older than b when (b-a) mod 16 lies in 1..7). Stores younger than a load never block it, never make its grant speculative, and never trigger a replay of it when they resolve.
- R6: When a store resolves, each executed load that is younger than the store and has the same address is a violation. The replay valid, load slot and load age appear on the cycle after the resolve. A different address or an older load gives no replay. The replayed load may request again.
- R7: When several loads violate against one resolving store, only the oldest of them by age is reported.
- R8: A violation sets the counter of that load's PC index (PC bits 5:2) to 0, so that later loads with that index are refused past unresolved older stores. Other indices keep their value.
- R9: Counters reset to 2. A load that retires after a speculative grant and no violation increments its counter, which saturates at 3 and never wraps.
- R10: A store resolving in the same cycle as a load request is treated as already resolved for that request. With a matching address the load is refused and no replay follows. With a differing address the load is granted non-speculatively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_alloc_vld | input | 1 | Allocate a store slot |
| st_alloc_slot | input | 3 | Store slot being allocated |
| st_alloc_age | input | 4 | Program-order age tag of the store |
| st_res_vld | input | 1 | Store address resolved this cycle |
| st_res_slot | input | 3 | Slot of the resolving store |
| st_res_addr | input | 32 | Resolved store word address |
| st_free_vld | input | 1 | Free a store slot |
| st_free_slot | input | 3 | Store slot being freed |
| ld_alloc_vld | input | 1 | Allocate a load slot |
| ld_alloc_slot | input | 3 | Load slot being allocated |
| ld_alloc_age | input | 4 | Program-order age tag of the load |
| ld_alloc_pc | input | 32 | Load PC; bits 5:2 select the predictor entry |
| ld_req_vld | input | 1 | Load asks to issue |
| ld_req_slot | input | 3 | Slot of the requesting load |
| ld_req_addr | input | 32 | Word address of the requesting load |
| ld_gnt | output | 1 | Load may issue this cycle |
| ld_gnt_spec | output | 1 | Grant passes at least one unresolved older store |
| ld_ret_vld | input | 1 | Retire a load slot |
| ld_ret_slot | input | 3 | Load slot being retired |
| rep_vld | output | 1 | A load must be re-executed |
| rep_slot | output | 3 | Slot of the load to replay |
| rep_age | output | 4 | Age tag of the load to replay |

## Verification
The assertions rely on the surrounding pipeline to use the block sensibly. It allocates only free slots, resolves only live stores and resolves each of them once. It requests issue only for live loads that have not executed. It never retires a load in the cycle its replay is reported. It also keeps all live age tags within a window of eight, so that modulo comparison gives program order. The stimulus follows these rules directly: every slot is freed before reuse, at most one event of each kind is sent per cycle, and ages step forward by one across the whole run, wrapping past 15 only after the older operations have retired.

// File: rtl/sld_pkg.sv
`timescale 1ns/1ps
package sld_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_TOP = 2'd3;
  localparam ctr_t CTR_GO  = 2'd2;

  // a strictly precedes b when (b - a) mod 2^w is nonzero and in the lower half
  function automatic logic age_before(input logic [15:0] a, input logic [15:0] b,
                                      input int unsigned w);
    logic [15:0] m;
    logic [15:0] d;
    m = 16'((32'd1 << w) - 32'd1);
    d = (b - a) & m;
    return (d != 16'd0) && !d[w-1];
  endfunction
endpackage

// File: rtl/sld_pred_tbl.sv
`timescale 1ns/1ps
module sld_pred_tbl
  import sld_pkg::*;
#(
  parameter int N    = 16,
  parameter int IW   = 4,
  parameter int INIT = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IW-1:0]       rd_idx,
  output logic                rd_ok,
  input  logic                inc_en,
  input  logic [IW-1:0]       inc_idx,
  input  logic                clr_en,
  input  logic [IW-1:0]       clr_idx,
  output logic [N-1:0][1:0]   ctr_o
);
  localparam ctr_t INIT_V = ctr_t'(INIT);

  logic [N-1:0][1:0] ctr_q;
  logic [N-1:0][1:0] ctr_d;

  always_comb begin
    ctr_d = ctr_q;
    if (inc_en && (ctr_q[inc_idx] != CTR_TOP)) ctr_d[inc_idx] = ctr_q[inc_idx] + 2'd1;
    if (clr_en) ctr_d[clr_idx] = 2'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctr_q <= {N{INIT_V}};
    else if (inc_en || clr_en) ctr_q <= ctr_d;
  end

  assign rd_ok = (ctr_q[rd_idx] >= CTR_GO);
  assign ctr_o = ctr_q;
endmodule

// File: rtl/sld_issue_gate.sv
`timescale 1ns/1ps
module sld_issue_gate
  import sld_pkg::*;
#(
  parameter int SQ_N = 8,
  parameter int AW   = 32,
  parameter int TW   = 4
) (
  input  logic [SQ_N-1:0]          st_v,
  input  logic [SQ_N-1:0]          st_k,
  input  logic [SQ_N-1:0][AW-1:0]  st_addr,
  input  logic [SQ_N-1:0][TW-1:0]  st_age,
  input  logic [TW-1:0]            ld_age,
  input  logic [AW-1:0]            ld_addr,
  input  logic                     pred_ok,
  output logic                     may_go,
  output logic                     passes_unknown
);
  logic [SQ_N-1:0] older;
  logic [SQ_N-1:0] clash;
  logic [SQ_N-1:0] unres;

  for (genvar i = 0; i < SQ_N; i++) begin : g_st
    assign older[i] = st_v[i] && age_before(16'(st_age[i]), 16'(ld_age), TW);
    assign clash[i] = older[i] && st_k[i] && (st_addr[i] == ld_addr);
    assign unres[i] = older[i] && !st_k[i];
  end

  assign passes_unknown = |unres;
  assign may_go         = !(|clash) && (!passes_unknown || pred_ok);
endmodule

// File: rtl/sld_viol_scan.sv
`timescale 1ns/1ps
module sld_viol_scan
  import sld_pkg::*;
#(
  parameter int LQ_N = 8,
  parameter int AW   = 32,
  parameter int TW   = 4,
  localparam int LIW = $clog2(LQ_N)
) (
  input  logic                     res_vld,
  input  logic [TW-1:0]            res_age,
  input  logic [AW-1:0]            res_addr,
  input  logic [LQ_N-1:0]          ld_v,
  input  logic [LQ_N-1:0]          ld_x,
  input  logic [LQ_N-1:0][AW-1:0]  ld_addr,
  input  logic [LQ_N-1:0][TW-1:0]  ld_age,
  output logic                     hit,
  output logic [LIW-1:0]           hit_slot
);
  logic [LQ_N-1:0] cand;
  logic [LQ_N-1:0] beaten;
  logic [LQ_N-1:0] pick;

  for (genvar j = 0; j < LQ_N; j++) begin : g_ld
    assign cand[j] = res_vld && ld_v[j] && ld_x[j] && (ld_addr[j] == res_addr) &&
                     age_before(16'(res_age), 16'(ld_age[j]), TW);
  end

  always_comb begin
    beaten = '0;
    for (int j = 0; j < LQ_N; j++) begin
      for (int k = 0; k < LQ_N; k++) begin
        if (k != j && cand[k] && age_before(16'(ld_age[k]), 16'(ld_age[j]), TW))
          beaten[j] = 1'b1;
      end
    end
  end

  assign pick = cand & ~beaten;
  assign hit  = |cand;

  always_comb begin
    hit_slot = '0;
    for (int j = LQ_N - 1; j >= 0; j--) begin
      if (pick[j]) hit_slot = LIW'(j);
    end
  end
endmodule

// File: rtl/spec_ld_order.sv
`timescale 1ns/1ps
module spec_ld_order
  import sld_pkg::*;
#(
  parameter int SQ_N      = 8,
  parameter int LQ_N      = 8,
  parameter int AW        = 32,
  parameter int TW        = 4,
  parameter int PCW       = 32,
  parameter int PRED_N    = 16,
  parameter int PC_LSB    = 2,
  parameter int PRED_INIT = 2,
  localparam int SIW = $clog2(SQ_N),
  localparam int LIW = $clog2(LQ_N),
  localparam int PIW = $clog2(PRED_N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            st_alloc_vld,
  input  logic [SIW-1:0]  st_alloc_slot,
  input  logic [TW-1:0]   st_alloc_age,
  input  logic            st_res_vld,
  input  logic [SIW-1:0]  st_res_slot,
  input  logic [AW-1:0]   st_res_addr,
  input  logic            st_free_vld,
  input  logic [SIW-1:0]  st_free_slot,
  input  logic            ld_alloc_vld,
  input  logic [LIW-1:0]  ld_alloc_slot,
  input  logic [TW-1:0]   ld_alloc_age,
  input  logic [PCW-1:0]  ld_alloc_pc,
  input  logic            ld_req_vld,
  input  logic [LIW-1:0]  ld_req_slot,
  input  logic [AW-1:0]   ld_req_addr,
  output logic            ld_gnt,
  output logic            ld_gnt_spec,
  input  logic            ld_ret_vld,
  input  logic [LIW-1:0]  ld_ret_slot,
  output logic            rep_vld,
  output logic [LIW-1:0]  rep_slot,
  output logic [TW-1:0]   rep_age
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q = rst_pipe[1];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{ld_alloc_pc[PCW-1:PC_LSB+PIW], ld_alloc_pc[PC_LSB-1:0]};

  // store queue state
  logic [SQ_N-1:0]         sq_v, sq_v_d, sq_k, sq_k_d;
  logic [SQ_N-1:0][AW-1:0] sq_addr;
  logic [SQ_N-1:0][TW-1:0] sq_age;
  // load queue state: live, executed, issued speculatively, hit a violation
  logic [LQ_N-1:0]         lq_v, lq_v_d, lq_x, lq_x_d, lq_s, lq_s_d, lq_f, lq_f_d;
  logic [LQ_N-1:0][AW-1:0] lq_addr;
  logic [LQ_N-1:0][TW-1:0] lq_age;
  logic [LQ_N-1:0][PIW-1:0] lq_pi;

  // store view seen by an issuing load: a resolve in this cycle counts as known
  logic [SQ_N-1:0]         sqe_k;
  logic [SQ_N-1:0][AW-1:0] sqe_addr;
  always_comb begin
    for (int i = 0; i < SQ_N; i++) begin
      if (st_res_vld && (st_res_slot == SIW'(i))) begin
        sqe_k[i]    = 1'b1;
        sqe_addr[i] = st_res_addr;
      end else begin
        sqe_k[i]    = sq_k[i];
        sqe_addr[i] = sq_addr[i];
      end
    end
  end

  logic                 pred_ok;
  logic                 gate_go, gate_unk;
  logic                 scan_hit;
  logic [LIW-1:0]       scan_slot;
  logic                 inc_en;
  logic [PRED_N-1:0][1:0] pred_ctr;

  sld_pred_tbl #(.N(PRED_N), .IW(PIW), .INIT(PRED_INIT)) u_pred (
    .clk     (clk),
    .rst_n   (rst_q),
    .rd_idx  (lq_pi[ld_req_slot]),
    .rd_ok   (pred_ok),
    .inc_en  (inc_en),
    .inc_idx (lq_pi[ld_ret_slot]),
    .clr_en  (scan_hit),
    .clr_idx (lq_pi[scan_slot]),
    .ctr_o   (pred_ctr)
  );

  sld_issue_gate #(.SQ_N(SQ_N), .AW(AW), .TW(TW)) u_gate (
    .st_v           (sq_v),
    .st_k           (sqe_k),
    .st_addr        (sqe_addr),
    .st_age         (sq_age),
    .ld_age         (lq_age[ld_req_slot]),
    .ld_addr        (ld_req_addr),
    .pred_ok        (pred_ok),
    .may_go         (gate_go),
    .passes_unknown (gate_unk)
  );

  sld_viol_scan #(.LQ_N(LQ_N), .AW(AW), .TW(TW)) u_scan (
    .res_vld  (st_res_vld),
    .res_age  (sq_age[st_res_slot]),
    .res_addr (st_res_addr),
    .ld_v     (lq_v),
    .ld_x     (lq_x),
    .ld_addr  (lq_addr),
    .ld_age   (lq_age),
    .hit      (scan_hit),
    .hit_slot (scan_slot)
  );

  assign ld_gnt      = ld_req_vld && gate_go;
  assign ld_gnt_spec = ld_gnt && gate_unk;
  assign inc_en      = ld_ret_vld && lq_s[ld_ret_slot] && !lq_f[ld_ret_slot];

  // next-state for control bits
  always_comb begin
    sq_v_d = sq_v;
    sq_k_d = sq_k;
    if (st_alloc_vld) begin
      sq_v_d[st_alloc_slot] = 1'b1;
      sq_k_d[st_alloc_slot] = 1'b0;
    end
    if (st_res_vld)  sq_k_d[st_res_slot]  = 1'b1;
    if (st_free_vld) sq_v_d[st_free_slot] = 1'b0;

    lq_v_d = lq_v;
    lq_x_d = lq_x;
    lq_s_d = lq_s;
    lq_f_d = lq_f;
    if (ld_alloc_vld) begin
      lq_v_d[ld_alloc_slot] = 1'b1;
      lq_x_d[ld_alloc_slot] = 1'b0;
      lq_s_d[ld_alloc_slot] = 1'b0;
      lq_f_d[ld_alloc_slot] = 1'b0;
    end
    if (ld_gnt) begin
      lq_x_d[ld_req_slot] = 1'b1;
      lq_s_d[ld_req_slot] = gate_unk;
    end
    if (scan_hit) begin
      lq_x_d[scan_slot] = 1'b0;
      lq_f_d[scan_slot] = 1'b1;
    end
    if (ld_ret_vld) lq_v_d[ld_ret_slot] = 1'b0;
  end

  // control registers
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      sq_v    <= '0;
      sq_k    <= '0;
      lq_v    <= '0;
      lq_x    <= '0;
      lq_s    <= '0;
      lq_f    <= '0;
      rep_vld <= 1'b0;
    end else begin
      sq_v    <= sq_v_d;
      sq_k    <= sq_k_d;
      lq_v    <= lq_v_d;
      lq_x    <= lq_x_d;
      lq_s    <= lq_s_d;
      lq_f    <= lq_f_d;
      rep_vld <= scan_hit;
    end
  end

  // payload registers, written only under their enables
  always_ff @(posedge clk) begin
    if (st_alloc_vld) sq_age[st_alloc_slot] <= st_alloc_age;
    if (st_res_vld)   sq_addr[st_res_slot]  <= st_res_addr;
    if (ld_alloc_vld) begin
      lq_age[ld_alloc_slot] <= ld_alloc_age;
      lq_pi[ld_alloc_slot]  <= ld_alloc_pc[PC_LSB +: PIW];
    end
    if (ld_gnt) lq_addr[ld_req_slot] <= ld_req_addr;
    if (scan_hit) begin
      rep_slot <= scan_slot;
      rep_age  <= lq_age[scan_slot];
    end
  end
endmodule

// File: rtl/sld_chk.sv
`timescale 1ns/1ps
module sld_chk #(
  parameter int LQ_N   = 8,
  parameter int PRED_N = 16,
  localparam int LIW = $clog2(LQ_N),
  localparam int PIW = $clog2(PRED_N)
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    ld_req_vld,
  input logic                    ld_gnt,
  input logic                    ld_gnt_spec,
  input logic                    st_res_vld,
  input logic                    rep_vld,
  input logic [LIW-1:0]          rep_slot,
  input logic [LQ_N-1:0]         lq_v,
  input logic [LQ_N-1:0]         lq_x,
  input logic [PRED_N-1:0][1:0]  pred_ctr,
  input logic                    clr_en,
  input logic [PIW-1:0]          clr_idx,
  input logic                    inc_en,
  input logic [PIW-1:0]          inc_idx
);
  AST_GNT_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    ld_gnt |-> ld_req_vld); // R2

  AST_SPEC_NEEDS_GNT: assert property (@(posedge clk) disable iff (!rst_n)
    ld_gnt_spec |-> ld_gnt); // R4

  AST_REP_FOLLOWS_RES: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld |-> $past(st_res_vld)); // R6

  AST_REP_LOAD_REARMED: assert property (@(posedge clk) disable iff (!rst_n)
    rep_vld |-> (lq_v[rep_slot] && !lq_x[rep_slot])); // R6

  AST_VIOL_CLEARS_CTR: assert property (@(posedge clk) disable iff (!rst_n)
    clr_en |=> (pred_ctr[$past(clr_idx)] == 2'd0)); // R8

  AST_CTR_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_en && !clr_en && pred_ctr[inc_idx] == 2'd3) |=> (pred_ctr[$past(inc_idx)] == 2'd3)); // R9
endmodule

bind spec_ld_order sld_chk #(.LQ_N(LQ_N), .PRED_N(PRED_N)) u_chk (
  .clk         (clk),
  .rst_n       (rst_q),
  .ld_req_vld  (ld_req_vld),
  .ld_gnt      (ld_gnt),
  .ld_gnt_spec (ld_gnt_spec),
  .st_res_vld  (st_res_vld),
  .rep_vld     (rep_vld),
  .rep_slot    (rep_slot),
  .lq_v        (lq_v),
  .lq_x        (lq_x),
  .pred_ctr    (pred_ctr),
  .clr_en      (scan_hit),
  .clr_idx     (lq_pi[scan_slot]),
  .inc_en      (inc_en),
  .inc_idx     (lq_pi[ld_ret_slot])
);

// File: tb/sim_spec_ld_order.sv
`timescale 1ns/1ps
module sim_spec_ld_order;
  logic        clk;
  logic        rst_n;
  logic        st_alloc_vld, st_res_vld, st_free_vld;
  logic [2:0]  st_alloc_slot, st_res_slot, st_free_slot;
  logic [3:0]  st_alloc_age;
  logic [31:0] st_res_addr;
  logic        ld_alloc_vld, ld_req_vld, ld_ret_vld;
  logic [2:0]  ld_alloc_slot, ld_req_slot, ld_ret_slot;
  logic [3:0]  ld_alloc_age;
  logic [31:0] ld_alloc_pc, ld_req_addr;
  logic        ld_gnt, ld_gnt_spec;
  logic        rep_vld;
  logic [2:0]  rep_slot;
  logic [3:0]  rep_age;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [6:0] exp_q[$];
  string      exp_r[$];

  spec_ld_order u0 (
    .clk(clk), .rst_n(rst_n),
    .st_alloc_vld(st_alloc_vld), .st_alloc_slot(st_alloc_slot), .st_alloc_age(st_alloc_age),
    .st_res_vld(st_res_vld), .st_res_slot(st_res_slot), .st_res_addr(st_res_addr),
    .st_free_vld(st_free_vld), .st_free_slot(st_free_slot),
    .ld_alloc_vld(ld_alloc_vld), .ld_alloc_slot(ld_alloc_slot), .ld_alloc_age(ld_alloc_age),
    .ld_alloc_pc(ld_alloc_pc),
    .ld_req_vld(ld_req_vld), .ld_req_slot(ld_req_slot), .ld_req_addr(ld_req_addr),
    .ld_gnt(ld_gnt), .ld_gnt_spec(ld_gnt_spec),
    .ld_ret_vld(ld_ret_vld), .ld_ret_slot(ld_ret_slot),
    .rep_vld(rep_vld), .rep_slot(rep_slot), .rep_age(rep_age)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(string r, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      while (exp_q.size() > 0) begin
        n_cmp++; n_bad++;
        $display("FAIL %s replay missing: actual none expected %0h", exp_r[0], exp_q[0]);
        void'(exp_q.pop_front());
        void'(exp_r.pop_front());
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  task automatic clr();
    st_alloc_vld = 0; st_res_vld = 0; st_free_vld = 0;
    ld_alloc_vld = 0; ld_req_vld = 0; ld_ret_vld = 0;
    st_alloc_slot = 0; st_alloc_age = 0; st_res_slot = 0; st_res_addr = 0; st_free_slot = 0;
    ld_alloc_slot = 0; ld_alloc_age = 0; ld_alloc_pc = 0;
    ld_req_slot = 0; ld_req_addr = 0; ld_ret_slot = 0;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
    clr();
  endtask

  task automatic sa(int s, int a);      st_alloc_vld = 1; st_alloc_slot = 3'(s); st_alloc_age = 4'(a); endtask
  task automatic sr(int s, int ad);     st_res_vld = 1; st_res_slot = 3'(s); st_res_addr = 32'(ad); endtask
  task automatic sf(int s);             st_free_vld = 1; st_free_slot = 3'(s); endtask
  task automatic la(int s, int a, int pc); ld_alloc_vld = 1; ld_alloc_slot = 3'(s); ld_alloc_age = 4'(a); ld_alloc_pc = 32'(pc); endtask
  task automatic lr(int s, int ad);     ld_req_vld = 1; ld_req_slot = 3'(s); ld_req_addr = 32'(ad); endtask
  task automatic lt(int s);             ld_ret_vld = 1; ld_ret_slot = 3'(s); endtask

  task automatic expect_gnt(string r, logic g, logic sp);
    #1;
    check(r, "ld_gnt", 32'(ld_gnt), 32'(g));
    check(r, "ld_gnt_spec", 32'(ld_gnt_spec), 32'(sp));
  endtask

  task automatic expect_rep(string r, int s, int a);
    exp_q.push_back({3'(s), 4'(a)});
    exp_r.push_back(r);
  endtask

  // scoreboard monitor: every reported replay must match the next expected item
  always @(negedge clk) begin
    if (rst_n && !done && rep_vld) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R6 unexpected replay: actual slot %0d age %0d expected none", rep_slot, rep_age);
      end else begin
        if ({rep_slot, rep_age} !== exp_q[0]) begin
          n_bad++;
          $display("FAIL %s replay: actual %0h expected %0h", exp_r[0], {rep_slot, rep_age}, exp_q[0]);
        end
        void'(exp_q.pop_front());
        void'(exp_r.pop_front());
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    clr();
    rst_n = 0;
    repeat (3) @(posedge clk);
    #1;
    check("R1", "rep_vld in reset", 32'(rep_vld), 0);
    rst_n = 1;
    repeat (3) step();
    check("R1", "rep_vld after reset", 32'(rep_vld), 0);
    check("R1", "ld_gnt idle", 32'(ld_gnt), 0);

    // R2: older store known, different address
    sa(0, 0); la(0, 1, 'h40); step();
    sr(0, 'h100); step();
    lr(0, 'h200); expect_gnt("R2", 1, 0); step();
    sf(0); lt(0); step();

    // R3: older store known, same address
    sa(1, 2); la(1, 3, 'h44); step();
    sr(1, 'h300); step();
    lr(1, 'h300); expect_gnt("R3", 0, 0); step();
    sf(1); step();
    lr(1, 'h300); expect_gnt("R3", 1, 0); step();
    lt(1); step();

    // R5: younger stores, one unresolved and one later matching, are ignored
    la(2, 4, 'h48); sa(2, 5); step();
    sa(3, 6); step();
    sr(3, 'h500); step();
    lr(2, 'h500); expect_gnt("R5", 1, 0); step();
    sr(2, 'h500); step();
    lt(2); sf(2); step();
    sf(3); step();

    // R4 + R6: speculative issue then violation on resolve
    sa(4, 7); la(3, 8, 'h40); step();
    lr(3, 'h400); expect_gnt("R4", 1, 1); step();
    sr(4, 'h400); expect_rep("R6", 3, 8); step();
    lr(3, 'h400); expect_gnt("R6", 0, 0); step();
    sf(4); step();
    lr(3, 'h400); expect_gnt("R6", 1, 0); step();
    lt(3); step();

    // R8: index 0 now cleared, index 1 untouched
    sa(5, 9); la(4, 10, 'h40); step();
    la(5, 11, 'h44); step();
    lr(4, 'h600); expect_gnt("R8", 0, 0); step();
    lr(5, 'h600); expect_gnt("R8", 1, 1); step();
    sr(5, 'h700); step();
    lr(4, 'h600); expect_gnt("R4", 1, 0); step();
    sf(5); step();
    lt(4); step();
    lt(5); step();

    // R9: repeated clean speculative retires keep permission (saturation), ages wrap
    for (int k = 0; k < 3; k++) begin
      sa(6, (12 + 2 * k) % 16); la(6, (13 + 2 * k) % 16, 'h44); step();
      lr(6, 'h800); expect_gnt("R9", 1, 1); step();
      sr(6, 'h900); step();
      sf(6); step();
      lt(6); step();
    end

    // R7: two younger loads violate, oldest reported; older load ignored (R6)
    la(0, 2, 'h4C); step();
    sa(0, 3); la(7, 4, 'h48); step();
    la(1, 5, 'h4C); step();
    lr(0, 'hA00); expect_gnt("R6", 1, 0); step();
    lr(7, 'hA00); expect_gnt("R7", 1, 1); step();
    lr(1, 'hA00); expect_gnt("R7", 1, 1); step();
    sr(0, 'hA00); expect_rep("R7", 7, 4); step();
    step();
    lt(0); step();
    sf(0); step();
    lt(7); step();
    lt(1); step();

    // R10: resolve in the same cycle as a request
    sa(1, 6); la(2, 7, 'h50); step();
    sr(1, 'hB00); lr(2, 'hB00); expect_gnt("R10", 0, 0); step();
    step();
    sf(1); step();
    lr(2, 'hB00); expect_gnt("R10", 1, 0); step();
    lt(2); step();
    sa(2, 8); la(3, 9, 'h54); step();
    sr(2, 'hC00); lr(3, 'hD00); expect_gnt("R10", 1, 0); step();
    sf(2); step();
    lt(3); step();

    repeat (3) step();
    finish_run();
  end
endmodule